// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Front-End

This block is the control logic on the device side of a 16-bit dynamic memory. The memory is addressed by a row strobe and by two column strobes, one for each byte lane. A fast internal clock samples the active-low strobes, the write and output-enable controls, the multiplexed address and the write data. The block decides from the order of their edges what kind of cycle the host is running: read, early write, late write, refresh with the row on the address pins, or refresh with the row taken from an internal counter (column strobe already low when the row strobe falls).

It latches the row and column addresses, raises a one-sample strobe for each latch, and issues per-lane write enables into a small register-file stand-in for the cell array. It drives a per-lane output enable and holds the last read word on the data output in extended-data-out fashion, so that data stays valid after the column strobe rises. The host sees the internal cycle kind, the latched addresses, the row most recently refreshed and the refresh counter. Analog sensing and real access delays are not modelled. Every decision is taken one clock after the pins are sampled.

Top module: `dcas_dram_front`

## Requirements
- R1: The merged column strobe goes active when the first of the two lane strobes falls and goes inactive only when the last of them rises. The column address is captured on that first fall. A cycle whose row strobe is high stays in its kind until both lane strobes are high.
- R2: If either lane strobe is low when the row strobe falls, the cycle is a counter refresh, reported as kind 5. The refreshed row equals the counter value, the counter advances by one, no lane write is issued and the outputs stay disabled.
- R3: The refresh counter is 9 bits wide and reads 0 after reset. After a counter refresh at 511 it reads 0.
- R4: Output enable bit 0 covers data bits 7:0 and may be set only while the lower strobe is low. Bit 1 covers bits 15:8 and may be set only while the upper strobe is low.
- R5: A read (kind 1) starts when the merged column strobe falls with write-enable high. It latches the stored word at {row, column}. A lane drives once that lane's strobe and output-enable are both low and write-enable is high, so output starts at the later of the column-strobe and output-enable falls.
- R6: If write-enable is low when the merged column strobe falls, the cycle is an early write (kind 2). The lanes whose strobes are low are written with the sampled data, and both output enables stay 0 for the whole cycle.
- R7: If write-enable falls while a read is open and a column strobe is low, the cycle becomes a late write (kind 3). The data is written to the lanes whose strobes are low and the output enables drop to 0.
- R8: Output-enable going high during a read clears both output enables. With the row strobe and both lane strobes high, both output enables are 0 and the kind is 0 (idle).
- R9: When the row strobe falls with both lane strobes high, the address is taken as the row and reported as the refreshed row. Until a column strobe falls the kind is 4 (row-only refresh).
- R10: Once the column strobe rises during a read, the data output and the output enables keep their values. The data output changes only at the next column-strobe fall, which loads the word at the new column.
- R11: After reset the kind is 0, the output enables are 0, the data output is 0, the counter is 0 and the array reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Held read word |
| drive_en | output | 2 | Per-lane output enable (bit 0 = bits 7:0) |
| cyc_kind | output | 3 | 0 idle, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh |
| row_addr | output | 9 | Latched row |
| col_addr | output | 9 | Latched column |
| row_stb | output | 1 | One-sample pulse when the row is latched |
| col_stb | output | 1 | One-sample pulse when the column is latched |
| byte_we | output | 2 | Per-lane write pulse into the array |
| rfsh_row | output | 9 | Row most recently refreshed |
| rfsh_cnt | output | 9 | Internal refresh counter |

## Verification
The assertions assume that every pin holds for at least two samples between changes. This means each edge is seen once and a lane strobe never falls in the same sample as the row strobe whose cycle it would classify. The stimulus moves one control at a time and waits three clocks after each change. Both lanes fall together on writes, so a write always covers the lanes picked for it. Random reads, early writes, late writes and counter refreshes over a small address space run against a bench-side word model. Directed sequences cover staggered lane strobes, the end of a cycle with the row strobe already high, page-mode column changes, output-enable withdrawal and the counter wrap.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
    typedef enum logic [2:0] {
        CK_IDLE  = 3'd0,
        CK_READ  = 3'd1,
        CK_EWR   = 3'd2,
        CK_LWR   = 3'd3,
        CK_RONLY = 3'd4,
        CK_CBR   = 3'd5
    } cyc_kind_e;
endpackage

// File: rtl/dcas_strobe_sync.sv
module dcas_strobe_sync #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          lcas_n,
    input  logic          ucas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          ras_lo,
    output logic          lcas_lo,
    output logic          ucas_lo,
    output logic          cas_lo,
    output logic          we_lo,
    output logic          oe_lo,
    output logic [AW-1:0] addr_s,
    output logic [DW-1:0] din_s,
    output logic          ras_fall,
    output logic          cas_fall,
    output logic          we_fall
);
    typedef struct packed {
        logic          ras_lo;
        logic          lcas_lo;
        logic          ucas_lo;
        logic          we_lo;
        logic          oe_lo;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic          ras_was;
        logic          cas_was;
        logic          we_was;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.ras_lo  = ~ras_n;
        s_d.lcas_lo = ~lcas_n;
        s_d.ucas_lo = ~ucas_n;
        s_d.we_lo   = ~we_n;
        s_d.oe_lo   = ~oe_n;
        s_d.addr    = addr;
        s_d.din     = din;
        s_d.ras_was = s_q.ras_lo;
        s_d.cas_was = s_q.lcas_lo | s_q.ucas_lo;
        s_d.we_was  = s_q.we_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ras_lo   = s_q.ras_lo;
    assign lcas_lo  = s_q.lcas_lo;
    assign ucas_lo  = s_q.ucas_lo;
    assign cas_lo   = s_q.lcas_lo | s_q.ucas_lo;
    assign we_lo    = s_q.we_lo;
    assign oe_lo    = s_q.oe_lo;
    assign addr_s   = s_q.addr;
    assign din_s    = s_q.din;
    assign ras_fall = s_q.ras_lo & ~s_q.ras_was;
    assign cas_fall = cas_lo & ~s_q.cas_was;
    assign we_fall  = s_q.we_lo & ~s_q.we_was;
endmodule

// File: rtl/dcas_cell_stub.sv
module dcas_cell_stub #(
    parameter int RB = 2,
    parameter int CB = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wr_lane,
    input  logic [RB-1:0] wr_row,
    input  logic [CB-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    input  logic [RB-1:0] rd_row,
    input  logic [CB-1:0] rd_col,
    output logic [DW-1:0] rd_word
);
    localparam int DEPTH = 1 << (RB + CB);
    localparam int LW    = DW / 2;

    logic [DW-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cell_q[i][g*LW +: LW] <= '0;
            end else if (wr_lane[g]) begin
                cell_q[{wr_row, wr_col}][g*LW +: LW] <= wr_data[g*LW +: LW];
            end
        end
    end

    assign rd_word = cell_q[{rd_row, rd_col}];
endmodule

// File: rtl/dcas_cycle_ctl.sv
module dcas_cycle_ctl
    import dcas_pkg::*;
#(
    parameter int AW    = 9,
    parameter int DW    = 16,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_lo,
    input  logic             lcas_lo,
    input  logic             ucas_lo,
    input  logic             cas_lo,
    input  logic             we_lo,
    input  logic             oe_lo,
    input  logic [AW-1:0]    addr_s,
    input  logic [DW-1:0]    din_s,
    input  logic             ras_fall,
    input  logic             cas_fall,
    input  logic             we_fall,
    input  logic [DW-1:0]    rd_word,
    output cyc_kind_e        kind,
    output logic [AW-1:0]    row,
    output logic [AW-1:0]    col,
    output logic             row_stb,
    output logic             col_stb,
    output logic [1:0]       wr_lane,
    output logic [DW-1:0]    wr_data,
    output logic [1:0]       drv,
    output logic [DW-1:0]    dout,
    output logic [AW-1:0]    rfsh_row,
    output logic [CNT_W-1:0] ref_cnt
);
    typedef struct packed {
        cyc_kind_e        kind;
        logic [AW-1:0]    row;
        logic [AW-1:0]    col;
        logic             row_stb;
        logic             col_stb;
        logic [1:0]       wr_lane;
        logic [DW-1:0]    wr_data;
        logic [1:0]       drv;
        logic [DW-1:0]    dout;
        logic [AW-1:0]    rfsh_row;
        logic [CNT_W-1:0] ref_cnt;
    } ctl_t;

    ctl_t r_d, r_q;
    logic [1:0] lane_lo;
    logic       access_open;

    assign lane_lo     = {ucas_lo, lcas_lo};
    assign access_open = (r_q.kind == CK_RONLY) || (r_q.kind == CK_READ) ||
                         (r_q.kind == CK_EWR)   || (r_q.kind == CK_LWR);

    always_comb begin
        r_d         = r_q;
        r_d.wr_lane = '0;
        r_d.row_stb = 1'b0;
        r_d.col_stb = 1'b0;
        if (ras_fall) begin
            if (cas_lo) begin
                r_d.kind     = CK_CBR;
                r_d.rfsh_row = AW'(r_q.ref_cnt);
                r_d.ref_cnt  = r_q.ref_cnt + 1'b1;
            end else begin
                r_d.kind     = CK_RONLY;
                r_d.row      = addr_s;
                r_d.rfsh_row = addr_s;
                r_d.row_stb  = 1'b1;
            end
        end else if (cas_fall && ras_lo && access_open) begin
            r_d.col     = addr_s;
            r_d.col_stb = 1'b1;
            if (we_lo) begin
                r_d.kind    = CK_EWR;
                r_d.wr_lane = lane_lo;
                r_d.wr_data = din_s;
            end else begin
                r_d.kind = CK_READ;
                r_d.dout = rd_word;
            end
        end else if (we_fall && cas_lo && ras_lo && r_q.kind == CK_READ) begin
            r_d.kind    = CK_LWR;
            r_d.wr_lane = lane_lo;
            r_d.wr_data = din_s;
        end
        if (!ras_lo && !cas_lo) r_d.kind = CK_IDLE;
        for (int b = 0; b < 2; b++) begin
            logic set_b, clr_b;
            set_b = (r_d.kind == CK_READ) && lane_lo[b] && oe_lo && !we_lo;
            clr_b = !oe_lo || we_lo || (!ras_lo && !cas_lo) || (cas_fall && !lane_lo[b]);
            r_d.drv[b] = set_b || (r_q.drv[b] && !clr_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{kind: CK_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign kind     = r_q.kind;
    assign row      = r_q.row;
    assign col      = r_q.col;
    assign row_stb  = r_q.row_stb;
    assign col_stb  = r_q.col_stb;
    assign wr_lane  = r_q.wr_lane;
    assign wr_data  = r_q.wr_data;
    assign drv      = r_q.drv;
    assign dout     = r_q.dout;
    assign rfsh_row = r_q.rfsh_row;
    assign ref_cnt  = r_q.ref_cnt;

    // R2
    cbr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && cas_lo) |=> (r_q.ref_cnt == $past(r_q.ref_cnt) + 1'b1));
    // R2
    cbr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && cas_lo) |=> (r_q.wr_lane == 2'b00));
    // R6
    ewr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.kind == CK_EWR) |-> (r_q.drv == 2'b00));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_lo && !cas_lo) |=> (r_q.drv == 2'b00));
    // R4
    lane_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drv[0]) |-> $past(lcas_lo));
    // R4
    lane_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drv[1]) |-> $past(ucas_lo));
    // R1
    col_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.col_stb |-> (r_q.col == $past(addr_s)));
    // R10
    edo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_fall) |=> $stable(r_q.dout));
endmodule

// File: rtl/dcas_dram_front.sv
module dcas_dram_front
    import dcas_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int DATA_W        = 16,
    parameter int CNT_W         = 9,
    parameter int STUB_ROW_BITS = 2,
    parameter int STUB_COL_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        drive_en,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              row_stb,
    output logic              col_stb,
    output logic [1:0]        byte_we,
    output logic [ADDR_W-1:0] rfsh_row,
    output logic [CNT_W-1:0]  rfsh_cnt
);
    logic ras_lo, lcas_lo, ucas_lo, cas_lo, we_lo, oe_lo;
    logic ras_fall, cas_fall, we_fall;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s, rd_word, wr_data;
    cyc_kind_e kind;

    dcas_strobe_sync #(.AW(ADDR_W), .DW(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .ras_lo(ras_lo), .lcas_lo(lcas_lo), .ucas_lo(ucas_lo), .cas_lo(cas_lo),
        .we_lo(we_lo), .oe_lo(oe_lo), .addr_s(addr_s), .din_s(din_s),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
    );

    dcas_cycle_ctl #(.AW(ADDR_W), .DW(DATA_W), .CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ras_lo(ras_lo), .lcas_lo(lcas_lo), .ucas_lo(ucas_lo),
        .cas_lo(cas_lo), .we_lo(we_lo), .oe_lo(oe_lo), .addr_s(addr_s), .din_s(din_s),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall), .rd_word(rd_word),
        .kind(kind), .row(row_addr), .col(col_addr), .row_stb(row_stb), .col_stb(col_stb),
        .wr_lane(byte_we), .wr_data(wr_data), .drv(drive_en), .dout(dout),
        .rfsh_row(rfsh_row), .ref_cnt(rfsh_cnt)
    );

    dcas_cell_stub #(.RB(STUB_ROW_BITS), .CB(STUB_COL_BITS), .DW(DATA_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_lane(byte_we),
        .wr_row(row_addr[STUB_ROW_BITS-1:0]), .wr_col(col_addr[STUB_COL_BITS-1:0]),
        .wr_data(wr_data),
        .rd_row(row_addr[STUB_ROW_BITS-1:0]), .rd_col(addr_s[STUB_COL_BITS-1:0]),
        .rd_word(rd_word)
    );

    assign cyc_kind = kind;
endmodule

// File: tb/sim_dcas_dram_front.sv
module sim_dcas_dram_front;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1, lcas_n = 1, ucas_n = 1, we_n = 1, oe_n = 1;
    logic [8:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0] drive_en, byte_we;
    logic [2:0] cyc_kind;
    logic [8:0] row_addr, col_addr, rfsh_row, rfsh_cnt;
    logic row_stb, col_stb;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem_m [32];
    logic [8:0] exp_cnt = '0;

    always #(CLK_P/2) clk = ~clk;

    dcas_dram_front u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .drive_en(drive_en), .cyc_kind(cyc_kind), .row_addr(row_addr), .col_addr(col_addr),
        .row_stb(row_stb), .col_stb(col_stb), .byte_we(byte_we),
        .rfsh_row(rfsh_row), .rfsh_cnt(rfsh_cnt)
    );

    function automatic int idx(input logic [8:0] r, input logic [8:0] c);
        return int'({r[1:0], c[2:0]});
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] lanes);
        logic [15:0] m;
        m = old;
        if (lanes[0]) m[7:0]  = nw[7:0];
        if (lanes[1]) m[15:8] = nw[15:8];
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_cycle();
        ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
        hold(3);
        check("R8 idle kind", 32'(cyc_kind), 0);
        check("R8 idle drive", 32'(drive_en), 0);
    endtask

    task automatic open_row(input logic [8:0] r);
        addr = r; hold(1); ras_n = 0; hold(3);
    endtask

    task automatic do_read(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes);
        open_row(r);
        addr = c; we_n = 1; oe_n = 0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; hold(3);
        check("R5 read kind", 32'(cyc_kind), 1);
        check("R5 read data", 32'(dout), 32'(mem_m[idx(r, c)]));
        check("R4 lane drive", 32'(drive_en), 32'(lanes));
        lcas_n = 1; ucas_n = 1; hold(3);
        check("R10 hold data", 32'(dout), 32'(mem_m[idx(r, c)]));
        check("R10 hold drive", 32'(drive_en), 32'(lanes));
        end_cycle();
    endtask

    task automatic do_ewrite(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes,
                             input logic [15:0] d);
        open_row(r);
        addr = c; din = d; we_n = 0; oe_n = 0; hold(2);
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; hold(3);
        check("R6 early kind", 32'(cyc_kind), 2);
        check("R6 early drive", 32'(drive_en), 0);
        mem_m[idx(r, c)] = merge(mem_m[idx(r, c)], d, lanes);
        end_cycle();
    endtask

    task automatic do_lwrite(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes,
                             input logic [15:0] d);
        open_row(r);
        addr = c; we_n = 1; oe_n = 1; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; hold(3);
        din = d; we_n = 0; hold(3);
        check("R7 late kind", 32'(cyc_kind), 3);
        check("R7 late drive", 32'(drive_en), 0);
        mem_m[idx(r, c)] = merge(mem_m[idx(r, c)], d, lanes);
        end_cycle();
    endtask

    task automatic do_cbr(input bit verify);
        lcas_n = 0; ucas_n = 0; addr = 9'h1AB; hold(2);
        ras_n = 0; hold(3);
        if (verify) begin
            check("R2 cbr kind", 32'(cyc_kind), 5);
            check("R2 cbr row", 32'(rfsh_row), 32'(exp_cnt));
            check("R2 cbr drive", 32'(drive_en), 0);
        end
        exp_cnt = exp_cnt + 1'b1;
        if (verify) check("R2 cbr count", 32'(rfsh_cnt), 32'(exp_cnt));
        ras_n = 1; lcas_n = 1; ucas_n = 1; hold(2);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] r, c, c2;
        logic [1:0] ln;
        for (int i = 0; i < 32; i++) mem_m[i] = '0;
        void'($urandom(32'h00C0FFEE));
        hold(3); rst_n = 1; hold(2);

        // R11 reset state
        check("R11 kind", 32'(cyc_kind), 0);
        check("R11 drive", 32'(drive_en), 0);
        check("R11 dout", 32'(dout), 0);
        check("R11 count", 32'(rfsh_cnt), 0);
        do_read(9'h003, 9'h005, 2'b11);

        // R9 row-only refresh
        open_row(9'h0C7);
        check("R9 kind", 32'(cyc_kind), 4);
        check("R9 rfsh row", 32'(rfsh_row), 32'h0C7);
        check("R9 row latch", 32'(row_addr), 32'h0C7);
        end_cycle();

        do_ewrite(9'h001, 9'h002, 2'b11, 16'hA55A);
        do_ewrite(9'h001, 9'h002, 2'b10, 16'h3C00);
        do_read(9'h001, 9'h002, 2'b01);
        do_lwrite(9'h002, 9'h006, 2'b01, 16'h00E7);
        do_read(9'h002, 9'h006, 2'b11);

        // R1 staggered lane strobes: column taken at the first fall
        open_row(9'h001);
        addr = 9'h002; oe_n = 0; lcas_n = 0; hold(3);
        addr = 9'h007; ucas_n = 0; hold(3);
        check("R1 col first fall", 32'(col_addr), 32'h002);
        check("R1 data first col", 32'(dout), 32'(mem_m[idx(9'h001, 9'h002)]));
        check("R4 both lanes", 32'(drive_en), 3);
        ras_n = 1; lcas_n = 1; hold(3);
        check("R1 still open", 32'(cyc_kind), 1);
        ucas_n = 1; hold(3);
        check("R1 closed at last rise", 32'(cyc_kind), 0);
        end_cycle();

        // R10 page mode column change, R8 output-enable withdrawal
        do_ewrite(9'h003, 9'h004, 2'b11, 16'h1234);
        open_row(9'h003);
        addr = 9'h002; oe_n = 0; lcas_n = 0; ucas_n = 0; hold(3);
        lcas_n = 1; ucas_n = 1; addr = 9'h004; hold(3);
        check("R10 held before fall", 32'(dout), 32'(mem_m[idx(9'h003, 9'h002)]));
        lcas_n = 0; ucas_n = 0; hold(3);
        check("R10 next column", 32'(dout), 32'h1234);
        oe_n = 1; hold(3);
        check("R8 oe withdraw", 32'(drive_en), 0);
        end_cycle();

        // R5 output starts at the later of column strobe and output enable
        open_row(9'h000);
        addr = 9'h000; oe_n = 1; lcas_n = 0; ucas_n = 0; hold(3);
        check("R5 no drive before oe", 32'(drive_en), 0);
        oe_n = 0; hold(3);
        check("R5 drive after oe", 32'(drive_en), 3);
        end_cycle();

        // random mix
        for (int k = 0; k < 120; k++) begin
            r  = 9'($urandom_range(0, 511));
            c  = 9'($urandom_range(0, 511));
            c2 = 9'($urandom_range(1, 3));
            ln = c2[1:0];
            case ($urandom_range(0, 3))
                0: do_ewrite(r, c, ln, 16'($urandom));
                1: do_lwrite(r, c, ln, 16'($urandom));
                2: do_read(r, c, ln);
                default: do_cbr(1'b1);
            endcase
        end

        // R3 wrap
        while (exp_cnt != 9'd511) do_cbr(1'b0);
        check("R3 at top", 32'(rfsh_cnt), 511);
        do_cbr(1'b1);
        check("R3 wrapped", 32'(rfsh_cnt), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule